// File: doc/BRIEF.md
# Event-Based Branch Dispatch Unit

This unit decides when a pending performance-monitor alert turns into a user-level event-based branch. When the alert is taken, the unit redirects the instruction stream to a software handler. It holds a small register group:

- a facility-enable register;
- a status register with a global-enable bit, a monitor-event-enable bit and an event-occurred flag;
- a return-address register;
- a handler-address register.

Software reads every register on dedicated output ports. It writes them through a single write-enable port with a two-bit select.

An alert raised by the performance monitor is latched as pending. The pending alert is serviced only while the core runs in user state, and servicing always consumes it. When all three enables are set at that moment, the branch is taken in one step:

- the current instruction pointer is saved into the return-address register;
- the global enable drops, so no further branch can be taken until software re-arms it;
- the occurred flag is set;
- a one-cycle registered redirect strobe presents the handler address as the next instruction pointer.

No privilege level changes, and no machine-state output exists.

Top module: `ebb_dispatch`

## Requirements
- R1: After reset, every register, the pending flag and the redirect strobe read zero.
- R2: `alert_raise` sets the pending flag one cycle later. While `user_mode` is low, a pending alert stays pending and no redirect occurs.
- R3: A pending alert seen while `user_mode` is high is consumed: the pending flag reads zero in the following cycle, unless `alert_raise` is high in that same cycle.
- R4: A branch is taken only when the serviced alert finds the facility enable (select 0, bit 0), the global enable (status bit 0) and the monitor-event enable (status bit 1) all set. Otherwise the alert is consumed with no redirect and no register change.
- R5: A taken branch makes `redirect_vld` high for exactly one cycle, starting the cycle after the decision. During that cycle `redirect_pc` equals the handler address held in the decision cycle.
- R6: A taken branch loads `cur_pc` from the decision cycle into the return-address register.
- R7: A taken branch clears the global enable and sets the occurred flag (status bit 2). Further alerts are then consumed without redirect until software sets the global enable again.
- R8: A software status write in the same cycle as a taken branch keeps its monitor-event-enable bit. Its global-enable and occurred bits are overridden by the branch updates.
- R9: A software write with `sw_we` high stores `sw_wdata` in the register picked by `sw_sel`, visible the next cycle. The select codes are 0 facility, 1 status, 2 return address and 3 handler address.
- R10: An `alert_raise` in the same cycle as a serviced alert leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | High while the core runs in user state |
| cur_pc | input | AW | Current instruction pointer |
| alert_raise | input | 1 | Performance-monitor alert pulse |
| sw_we | input | 1 | Software register write enable |
| sw_sel | input | 2 | Register select: 0 facility, 1 status, 2 return, 3 handler |
| sw_wdata | input | AW | Software write data |
| alert_pending | output | 1 | Pending-alert flag |
| redirect_vld | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | AW | Next instruction pointer, valid with the strobe |
| fac_en | output | 1 | Facility-enable bit |
| stat_o | output | 3 | Status: bit 2 occurred, bit 1 monitor enable, bit 0 global enable |
| ret_addr | output | AW | Return-address register |
| hdl_addr | output | AW | Handler-address register |

## Verification
The dispatch decision is tried with four patterns:

- an alert raised while outside user state, which separates holding the alert from servicing it;
- the fully enabled case, which checks the target, the saved return address and the status update together;
- each enable cleared in turn, which shows that every gate blocks the branch on its own while the alert is still consumed;
- collisions in a single cycle, both a status write and a fresh alert arriving together with a taken branch, which separate hardware priority on the status bits from the software value.

A scoreboard matches every redirect against the handler address expected at that moment, so a stray or missing strobe shows up.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

    typedef enum logic [1:0] {
        SEL_FAC  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_RET  = 2'd2,
        SEL_HDL  = 2'd3
    } ebb_sel_e;

    typedef struct packed {
        logic occ;
        logic mon_en;
        logic glob_en;
    } ebb_stat_t;

    localparam int unsigned STAT_W = $bits(ebb_stat_t);

    function automatic logic gates_open(logic fac, ebb_stat_t s);
        return fac & s.glob_en & s.mon_en;
    endfunction

endpackage

// File: rtl/ebb_regfile.sv
module ebb_regfile
    import ebb_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  ebb_sel_e      sw_sel,
    input  logic [AW-1:0] sw_wdata,
    input  logic          take,
    input  logic [AW-1:0] cur_pc,
    output logic          fac_q,
    output ebb_stat_t     stat_q,
    output logic [AW-1:0] ret_q,
    output logic [AW-1:0] hdl_q
);

    logic          fac_d;
    ebb_stat_t     stat_d;
    logic [AW-1:0] ret_d;
    logic [AW-1:0] hdl_d;

    always_comb begin
        fac_d  = fac_q;
        stat_d = stat_q;
        ret_d  = ret_q;
        hdl_d  = hdl_q;
        if (sw_we) begin
            case (sw_sel)
                SEL_FAC:  fac_d  = sw_wdata[0];
                SEL_STAT: stat_d = ebb_stat_t'(sw_wdata[STAT_W-1:0]);
                SEL_RET:  ret_d  = sw_wdata;
                SEL_HDL:  hdl_d  = sw_wdata;
                default:  fac_d  = fac_q;
            endcase
        end
        if (take) begin
            stat_d.glob_en = 1'b0;
            stat_d.occ     = 1'b1;
            ret_d          = cur_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fac_q  <= 1'b0;
            stat_q <= '0;
            ret_q  <= '0;
            hdl_q  <= '0;
        end else begin
            fac_q  <= fac_d;
            stat_q <= stat_d;
            ret_q  <= ret_d;
            hdl_q  <= hdl_d;
        end
    end

    p_take_status_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (!stat_q.glob_en && stat_q.occ));

    p_save_return_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> (ret_q == $past(cur_pc)));

    p_keep_monen_r8: assert property (@(posedge clk) disable iff (rst)
        (take && sw_we && sw_sel == SEL_STAT) |=> (stat_q.mon_en == $past(sw_wdata[1])));

    p_hdl_write_r9: assert property (@(posedge clk) disable iff (rst)
        (sw_we && sw_sel == SEL_HDL) |=> (hdl_q == $past(sw_wdata)));

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!take && !sw_we) |=> ($stable(stat_q) && $stable(ret_q) && $stable(fac_q)));

endmodule

// File: rtl/ebb_arbiter.sv
module ebb_arbiter
    import ebb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      alert_raise,
    input  logic      user_mode,
    input  logic      fac_en,
    input  ebb_stat_t stat,
    output logic      pending_q,
    output logic      take
);

    logic service;

    assign service = pending_q & user_mode;
    assign take    = service & gates_open(fac_en, stat);

    always_ff @(posedge clk) begin
        if (rst) pending_q <= 1'b0;
        else     pending_q <= alert_raise | (pending_q & ~service);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (pending_q && !user_mode) |=> pending_q);

    p_consume_r3: assert property (@(posedge clk) disable iff (rst)
        (pending_q && user_mode && !alert_raise) |=> !pending_q);

    p_raise_wins_r10: assert property (@(posedge clk) disable iff (rst)
        alert_raise |=> pending_q);

endmodule

// File: rtl/ebb_redirect.sv
module ebb_redirect #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] target,
    output logic          vld_q,
    output logic [AW-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pc_q  <= '0;
        end else begin
            vld_q <= take;
            if (take) pc_q <= target;
        end
    end

endmodule

// File: rtl/ebb_dispatch.sv
module ebb_dispatch
    import ebb_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              user_mode,
    input  logic [AW-1:0]     cur_pc,
    input  logic              alert_raise,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [AW-1:0]     sw_wdata,
    output logic              alert_pending,
    output logic              redirect_vld,
    output logic [AW-1:0]     redirect_pc,
    output logic              fac_en,
    output logic [STAT_W-1:0] stat_o,
    output logic [AW-1:0]     ret_addr,
    output logic [AW-1:0]     hdl_addr
);

    logic      take;
    ebb_stat_t stat_q;

    ebb_regfile #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_sel   (ebb_sel_e'(sw_sel)),
        .sw_wdata (sw_wdata),
        .take     (take),
        .cur_pc   (cur_pc),
        .fac_q    (fac_en),
        .stat_q   (stat_q),
        .ret_q    (ret_addr),
        .hdl_q    (hdl_addr)
    );

    ebb_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .alert_raise (alert_raise),
        .user_mode   (user_mode),
        .fac_en      (fac_en),
        .stat        (stat_q),
        .pending_q   (alert_pending),
        .take        (take)
    );

    ebb_redirect #(.AW(AW)) u_redir (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .target (hdl_addr),
        .vld_q  (redirect_vld),
        .pc_q   (redirect_pc)
    );

    assign stat_o = stat_q;

    p_gated_r4: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |-> ($past(user_mode) && $past(fac_en) && $past(stat_o[0]) && $past(stat_o[1])));

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |=> !redirect_vld);

    p_target_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |-> (redirect_pc == $past(hdl_addr)));

endmodule

// File: tb/sim_ebb_dispatch.sv
module sim_ebb_dispatch;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          user_mode = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic          alert_raise = 1'b0;
    logic          sw_we = 1'b0;
    logic [1:0]    sw_sel = '0;
    logic [AW-1:0] sw_wdata = '0;
    logic          alert_pending, redirect_vld, fac_en;
    logic [AW-1:0] redirect_pc, ret_addr, hdl_addr;
    logic [2:0]    stat_o;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] exp_q[$];

    always #10 clk = ~clk;

    ebb_dispatch #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .user_mode(user_mode), .cur_pc(cur_pc),
        .alert_raise(alert_raise), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .alert_pending(alert_pending),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .fac_en(fac_en), .stat_o(stat_o), .ret_addr(ret_addr),
        .hdl_addr(hdl_addr)
    );

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every strobe must match the oldest queued target.
    always @(negedge clk) begin
        if (!rst && redirect_vld) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected redirect", 32'd1, 32'd0);
            end else begin
                check("R5 redirect target", redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic sw_write(logic [1:0] sel, logic [AW-1:0] data);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
        cyc();
        sw_we = 1'b0;
    endtask

    task automatic raise();
        alert_raise = 1'b1;
        cyc();
        alert_raise = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        check("watchdog", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        // R1 reset state
        check("R1 pending", {31'd0, alert_pending}, 32'd0);
        check("R1 redirect", {31'd0, redirect_vld}, 32'd0);
        check("R1 status", {29'd0, stat_o}, 32'd0);
        check("R1 ret", ret_addr, 32'd0);

        // R9 register writes
        sw_write(2'd3, 32'h1000_0040);
        check("R9 handler", hdl_addr, 32'h1000_0040);
        sw_write(2'd0, 32'h1);
        check("R9 facility", {31'd0, fac_en}, 32'd1);
        sw_write(2'd1, 32'h3);
        check("R9 status", {29'd0, stat_o}, 32'd3);
        sw_write(2'd2, 32'h0000_0abc);
        check("R9 return", ret_addr, 32'h0000_0abc);

        // R2 alert held outside user state
        raise();
        check("R2 pending set", {31'd0, alert_pending}, 32'd1);
        repeat (3) cyc();
        check("R2 still pending", {31'd0, alert_pending}, 32'd1);

        // R5 R6 R7 taken branch
        cur_pc = 32'h0000_2000;
        user_mode = 1'b1;
        exp_q.push_back(32'h1000_0040);
        cyc();
        check("R3 consumed", {31'd0, alert_pending}, 32'd0);
        check("R6 return saved", ret_addr, 32'h0000_2000);
        check("R7 status", {29'd0, stat_o}, 32'b110);
        check("R5 strobe high", {31'd0, redirect_vld}, 32'd1);
        cyc();
        check("R5 strobe single", {31'd0, redirect_vld}, 32'd0);

        // R7 blocked while global enable clear; R4 no change
        cur_pc = 32'h0000_3000;
        raise();
        cyc();
        check("R7 blocked consumed", {31'd0, alert_pending}, 32'd0);
        check("R4 return kept", ret_addr, 32'h0000_2000);

        // R4 facility clear
        sw_write(2'd1, 32'h3);
        sw_write(2'd0, 32'h0);
        raise();
        cyc();
        check("R4 fac off pending", {31'd0, alert_pending}, 32'd0);
        check("R4 fac off status", {29'd0, stat_o}, 32'b011);
        // R4 monitor enable clear
        sw_write(2'd0, 32'h1);
        sw_write(2'd1, 32'h1);
        raise();
        cyc();
        check("R4 mon off status", {29'd0, stat_o}, 32'b001);
        check("R4 mon off return", ret_addr, 32'h0000_2000);

        // R8 collision of software status write with a branch
        sw_write(2'd1, 32'h3);
        user_mode = 1'b0;
        raise();
        cur_pc = 32'h0000_4000;
        user_mode = 1'b1;
        exp_q.push_back(32'h1000_0040);
        sw_write(2'd1, 32'h1);
        check("R8 status", {29'd0, stat_o}, 32'b100);
        check("R8 return", ret_addr, 32'h0000_4000);

        // R10 fresh alert during a taken branch
        sw_write(2'd3, 32'h2000_0080);
        sw_write(2'd1, 32'h3);
        user_mode = 1'b0;
        raise();
        user_mode = 1'b1;
        cur_pc = 32'h0000_5000;
        exp_q.push_back(32'h2000_0080);
        raise();
        check("R10 still pending", {31'd0, alert_pending}, 32'd1);
        cyc();
        check("R10 then consumed", {31'd0, alert_pending}, 32'd0);
        check("R6 second return", ret_addr, 32'h0000_5000);

        repeat (2) cyc();
        check("R5 all strobes seen", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule